// File: doc/BRIEF.md
# Packed Single-Precision Pre-Arithmetic Exception Screen

This block sits in front of a four-lane single-precision arithmetic datapath. Each transaction carries an operation code, four pairs of IEEE-754 single-precision operands and the current control/status word. Before any arithmetic is done, each lane is checked for the exception classes that can be found on the operands alone: invalid operation, divide-by-zero and denormal operand.

The block then decides one of two outcomes. If any lane raises one of these classes while its mask bit is clear, the whole instruction faults and nothing is written in any lane. Otherwise each lane either gets a fixed default result from the screen or is marked for the arithmetic datapath to compute. In both cases the sticky flag field is updated.

The overflow, underflow and inexact flags come from the datapath as inputs and are only merged into the sticky flags. The screen has one registered stage with a valid/ready handshake on each side.

Top module: `simd_prescreen`

## Requirements
- R1: A transaction is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its result appears on the outputs with `out_valid` high after that same edge. `in_ready` is high when the output stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold their values and no new transaction is accepted.
- R2: While `rst_n` is low on a rising edge, the output stage empties (`out_valid` low), and `in_ready` is high afterwards.
- R3: For add (`in_op`=0), subtract (1) and divide (2), a signaling NaN operand (exponent all ones, fraction non-zero, fraction bit 22 clear) raises invalid. When invalid is masked, the lane result is the NaN of operand a if a is any NaN, otherwise the NaN of operand b, with bit 22 set.
- R4: A quiet NaN operand (bit 22 set) in add, subtract or divide does not raise invalid. The lane is written by the screen with operand a if a is a NaN, otherwise with operand b.
- R5: Invalid is raised for infinities of opposite sign under add, infinities of equal sign under subtract, and for zero divided by zero and infinity divided by infinity. When masked, the lane result is 0xFFC00000.
- R6: For convert-to-integer (`in_op`=3), only operand a is examined. A NaN of either kind, an infinity, or a magnitude of at least 2^31 other than exactly -2^31 (0xCF000000) raises invalid. When masked, the lane result is 0x80000000. Operand b raises nothing.
- R7: Under divide, a finite non-zero a divided by a zero b raises divide-by-zero. When masked, the lane result is an infinity whose sign is the XOR of the operand signs.
- R8: An examined operand with a zero exponent and a non-zero fraction raises denormal, unless that lane raised invalid. A lane that only raises denormal is passed to the datapath.
- R9: If any lane raises invalid, denormal or divide-by-zero while the matching mask bit is clear, `out_fault` is high and `out_wr`, `out_pass` and `out_res` are all zero.
- R10: The status word keeps its flags at bit 0 (invalid), 1 (denormal), 2 (divide-by-zero), 3 (overflow), 4 (underflow) and 5 (inexact), with the matching mask bits at 7 to 12. `out_csr` equals `in_csr` with each flag ORed with that class's result over all four lanes. `in_post[0]`, `in_post[1]` and `in_post[2]` are ORed into overflow, underflow and inexact. This update also happens on a fault. All other bits pass through unchanged.
- R11: Without a fault, every lane has exactly one of `out_wr` (screen default result in `out_res`) or `out_pass` (datapath computes it, `out_res` lane is zero). Lane i occupies bits 32i+31 to 32i of the operand and result buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Transaction offered |
| in_ready | output | 1 | Transaction can be taken |
| in_op | input | 2 | 0 add, 1 subtract, 2 divide, 3 convert to integer |
| in_a | input | 128 | First operands, four lanes |
| in_b | input | 128 | Second operands, four lanes |
| in_csr | input | 32 | Current control/status word |
| in_post | input | 3 | Post-computation flags: overflow, underflow, inexact |
| out_valid | output | 1 | Result stage holds a transaction |
| out_ready | input | 1 | Consumer takes the result |
| out_fault | output | 1 | Unmasked pre-computation exception |
| out_res | output | 128 | Default results for screen-written lanes |
| out_wr | output | 4 | Lane written by the screen |
| out_pass | output | 4 | Lane sent to the arithmetic datapath |
| out_csr | output | 32 | Updated control/status word |

## Verification
Every result of a transaction, whether lane value, lane marks, fault or status word, is due in the cycle after the rising edge that accepts it, because there is exactly one register between input and output. The bench changes inputs on falling edges and reads the outputs on the falling edge right after the accepting edge. For the stall scenario it reads them again on later falling edges while `out_ready` is low, and then once more after the edge where the held result leaves and the queued transaction enters.

// File: rtl/prescreen_pkg.sv
// Package: shared constants and types for the packed exception screen.
// Assumes single-precision (32-bit) lanes; the lane count is a parameter elsewhere.
package prescreen_pkg;

    localparam int FP_W      = 32;
    localparam int EXP_W     = 8;
    localparam int FRAC_W    = 23;
    localparam int EXP_LSB   = FRAC_W;
    localparam int QUIET_BIT = FRAC_W - 1;
    localparam int CSR_W     = 32;

    // flag positions in the status word; the mask for flag k sits at k + MSK_OFS
    localparam int FLG_INV   = 0;
    localparam int FLG_DEN   = 1;
    localparam int FLG_DZ    = 2;
    localparam int FLG_OVF   = 3;
    localparam int FLG_UNF   = 4;
    localparam int FLG_PRE   = 5;
    localparam int MSK_OFS   = 7;
    localparam int N_PRE     = 3;   // classes found before arithmetic
    localparam int N_POST    = 3;   // classes found after arithmetic

    localparam logic [FP_W-1:0] FLT_INDEF = 32'hFFC0_0000;
    localparam logic [FP_W-1:0] INT_INDEF = 32'h8000_0000;
    localparam logic [FP_W-1:0] INT_MIN_F = 32'hCF00_0000;   // -2^31 exactly
    localparam logic [EXP_W-1:0] CVT_EXP_LIMIT = 8'd158;      // biased exponent of 2^31

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_DIV = 2'd2,
        OP_CVT = 2'd3
    } scr_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic inf;
        logic nan;
        logic snan;
        logic den;
    } fp_kind_t;

    typedef struct packed {
        logic inv;
        logic den;
        logic dz;
    } lane_exc_t;

endpackage

// File: rtl/prescreen_classify.sv
// Operand classifier: splits one single-precision value into the kinds the
// screen decides on. Purely combinational; assumes IEEE-754 binary32 layout.
module prescreen_classify
    import prescreen_pkg::*;
(
    input  logic [FP_W-1:0] val,
    output fp_kind_t        kind
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    // field split and edge-value tests
    always_comb begin
        exp_f   = val[FP_W-2:EXP_LSB];
        frac_f  = val[FRAC_W-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;
    end

    // kind vector
    always_comb begin
        kind.sign = val[FP_W-1];
        kind.zero = exp_min && !frac_nz;
        kind.den  = exp_min && frac_nz;
        kind.inf  = exp_max && !frac_nz;
        kind.nan  = exp_max && frac_nz;
        kind.snan = exp_max && frac_nz && !frac_f[QUIET_BIT];
    end

endmodule

// File: rtl/prescreen_lane.sv
// Lane screen: finds invalid, divide-by-zero and denormal for one operand
// pair and picks the default result the screen would write when masked.
// Assumes masks are applied later; this module reports raw classes only.
module prescreen_lane
    import prescreen_pkg::*;
(
    input  scr_op_e         op,
    input  logic [FP_W-1:0] opa,
    input  logic [FP_W-1:0] opb,
    output lane_exc_t       exc,
    output logic            take,
    output logic [FP_W-1:0] dflt
);

    fp_kind_t ka;
    fp_kind_t kb;

    prescreen_classify cls_a_i (.val(opa), .kind(ka));
    prescreen_classify cls_b_i (.val(opb), .kind(kb));

    logic is_cvt;
    logic inf_clash;
    logic div_inv;
    logic cvt_oor;
    logic arith_inv;
    logic cvt_inv;
    logic any_nan;
    logic a_finite_nz;
    logic [FP_W-1:0] nan_src;

    // operation-specific invalid conditions
    always_comb begin
        is_cvt      = (op == OP_CVT);
        inf_clash   = ka.inf && kb.inf &&
                      (((op == OP_ADD) && (ka.sign != kb.sign)) ||
                       ((op == OP_SUB) && (ka.sign == kb.sign)));
        div_inv     = (op == OP_DIV) &&
                      ((ka.zero && kb.zero) || (ka.inf && kb.inf));
        cvt_oor     = (opa[FP_W-2:EXP_LSB] >= CVT_EXP_LIMIT) && (opa != INT_MIN_F);
        cvt_inv     = ka.nan || ka.inf || cvt_oor;
        arith_inv   = ka.snan || kb.snan || inf_clash || div_inv;
        any_nan     = ka.nan || kb.nan;
        a_finite_nz = !ka.nan && !ka.inf && !ka.zero;
        nan_src     = ka.nan ? opa : opb;
    end

    // raw exception classes of the lane
    always_comb begin
        exc.inv = is_cvt ? cvt_inv : arith_inv;
        exc.dz  = (op == OP_DIV) && kb.zero && a_finite_nz;
        exc.den = !exc.inv && (ka.den || (!is_cvt && kb.den));
    end

    // default result selection, highest priority first
    always_comb begin
        take = 1'b1;
        dflt = '0;
        if (exc.inv) begin
            if (is_cvt) begin
                dflt = INT_INDEF;
            end else if (any_nan) begin
                dflt = nan_src;
                dflt[QUIET_BIT] = 1'b1;
            end else begin
                dflt = FLT_INDEF;
            end
        end else if (!is_cvt && any_nan) begin
            dflt = nan_src;
        end else if (exc.dz) begin
            dflt = {ka.sign ^ kb.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            take = 1'b0;
        end
    end

endmodule

// File: rtl/prescreen_csr.sv
// Status merge: ORs lane classes and post-arithmetic flags into the sticky
// flags and decides the fault from the pre-arithmetic mask bits.
// Assumes flag k's mask lives at bit k + MSK_OFS.
module prescreen_csr
    import prescreen_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0]  inv_v,
    input  logic [LANES-1:0]  den_v,
    input  logic [LANES-1:0]  dz_v,
    input  logic [CSR_W-1:0]  csr_in,
    input  logic [N_POST-1:0] post,
    output logic              fault,
    output logic [CSR_W-1:0]  csr_out
);

    logic [N_PRE-1:0] pre_hit;
    logic [N_PRE-1:0] pre_open;

    // per-class OR over lanes and the unmasked subset
    always_comb begin
        pre_hit[FLG_INV] = |inv_v;
        pre_hit[FLG_DEN] = |den_v;
        pre_hit[FLG_DZ]  = |dz_v;
        pre_open         = pre_hit & ~csr_in[MSK_OFS + N_PRE - 1 : MSK_OFS];
        fault            = |pre_open;
    end

    // sticky update of the flag field; everything else passes through
    always_comb begin
        csr_out = csr_in;
        csr_out[N_PRE-1:0]               = csr_in[N_PRE-1:0] | pre_hit;
        csr_out[FLG_PRE:FLG_OVF]         = csr_in[FLG_PRE:FLG_OVF] | post;
    end

endmodule

// File: rtl/simd_prescreen.sv
// Top: packed single-precision exception screen with one registered stage.
// Lanes are screened in parallel; a fault on any lane blocks all lanes.
// Assumes the consumer honours out_valid/out_ready; synchronous active-low reset.
module simd_prescreen
    import prescreen_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [1:0]              in_op,
    input  logic [LANES*FP_W-1:0]   in_a,
    input  logic [LANES*FP_W-1:0]   in_b,
    input  logic [CSR_W-1:0]        in_csr,
    input  logic [N_POST-1:0]       in_post,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_fault,
    output logic [LANES*FP_W-1:0]   out_res,
    output logic [LANES-1:0]        out_wr,
    output logic [LANES-1:0]        out_pass,
    output logic [CSR_W-1:0]        out_csr
);

    localparam int BUS_W = LANES * FP_W;

    scr_op_e            op_q;
    logic [LANES-1:0]   inv_v;
    logic [LANES-1:0]   den_v;
    logic [LANES-1:0]   dz_v;
    logic [LANES-1:0]   take_v;
    logic [BUS_W-1:0]   dflt_bus;
    logic               fault_c;
    logic [CSR_W-1:0]   csr_c;
    logic               accept;

    // operation code decode
    always_comb op_q = scr_op_e'(in_op);

    for (genvar li = 0; li < LANES; li++) begin : g_lane
        lane_exc_t exc_l;
        prescreen_lane lane_i (
            .op   (op_q),
            .opa  (in_a[li*FP_W +: FP_W]),
            .opb  (in_b[li*FP_W +: FP_W]),
            .exc  (exc_l),
            .take (take_v[li]),
            .dflt (dflt_bus[li*FP_W +: FP_W])
        );
        // unpack lane classes into per-class vectors
        always_comb begin
            inv_v[li] = exc_l.inv;
            den_v[li] = exc_l.den;
            dz_v[li]  = exc_l.dz;
        end
    end

    prescreen_csr #(.LANES(LANES)) csr_i (
        .inv_v   (inv_v),
        .den_v   (den_v),
        .dz_v    (dz_v),
        .csr_in  (in_csr),
        .post    (in_post),
        .fault   (fault_c),
        .csr_out (csr_c)
    );

    // handshake: stage is free when empty or being drained
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // output stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_res   <= '0;
            out_wr    <= '0;
            out_pass  <= '0;
            out_csr   <= '0;
        end else begin
            if (in_ready) begin
                out_valid <= in_valid;
            end
            if (accept) begin
                out_fault <= fault_c;
                out_res   <= fault_c ? '0 : dflt_bus;
                out_wr    <= fault_c ? '0 : take_v;
                out_pass  <= fault_c ? '0 : ~take_v;
                out_csr   <= csr_c;
            end
        end
    end

endmodule

// File: rtl/simd_prescreen_chk.sv
// Checker: temporal properties of the screen's ports, bound to the top.
// Assumes the flag/mask layout of prescreen_pkg.
module simd_prescreen_chk
    import prescreen_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [CSR_W-1:0]      in_csr,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic                  out_fault,
    input logic [LANES*FP_W-1:0] out_res,
    input logic [LANES-1:0]      out_wr,
    input logic [LANES-1:0]      out_pass,
    input logic [CSR_W-1:0]      out_csr
);

    assert_reset_empty_R2: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_accept_shows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_csr)
                                    && $stable(out_wr) && $stable(out_fault));

    assert_fault_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |-> out_wr == '0 && out_pass == '0 && out_res == '0);

    assert_fault_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |->
            (out_csr[N_PRE-1:0] & ~out_csr[MSK_OFS + N_PRE - 1 : MSK_OFS]) != '0);

    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=>
            (out_csr[FLG_PRE:0] & $past(in_csr[FLG_PRE:0])) == $past(in_csr[FLG_PRE:0]));

    assert_ctrl_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_csr[CSR_W-1:FLG_PRE+1] == $past(in_csr[CSR_W-1:FLG_PRE+1]));

    assert_lane_partition_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault |-> (out_wr & out_pass) == '0 && (out_wr | out_pass) == '1);

endmodule

bind simd_prescreen simd_prescreen_chk #(.LANES(LANES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_csr    (in_csr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_fault (out_fault),
    .out_res   (out_res),
    .out_wr    (out_wr),
    .out_pass  (out_pass),
    .out_csr   (out_csr)
);

// File: tb/simd_prescreen_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each task checks its own results.
module simd_prescreen_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_op = 2'd0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic [31:0]  in_csr = '0;
    logic [2:0]   in_post = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic         out_fault;
    logic [127:0] out_res;
    logic [3:0]   out_wr;
    logic [3:0]   out_pass;
    logic [31:0]  out_csr;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] M3   = 32'hC040_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] MSK_ALL = 32'h0000_1F80;

    always #2.5 clk = ~clk;

    simd_prescreen dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b),
        .in_csr(in_csr), .in_post(in_post),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_fault(out_fault), .out_res(out_res),
        .out_wr(out_wr), .out_pass(out_pass), .out_csr(out_csr)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic fault, input logic [3:0] wr,
                           input logic [3:0] pass, input logic [127:0] res,
                           input logic [31:0] csr);
        chk(req, "out_valid", {127'd0, out_valid}, 128'd1);
        chk(req, "out_fault", {127'd0, out_fault}, {127'd0, fault});
        chk(req, "out_wr",    {124'd0, out_wr},    {124'd0, wr});
        chk(req, "out_pass",  {124'd0, out_pass},  {124'd0, pass});
        chk(req, "out_res",   out_res,             res);
        chk(req, "out_csr",   {96'd0, out_csr},    {96'd0, csr});
    endtask

    // one transaction; outputs are read on the falling edge after acceptance
    task automatic run_txn(input logic [1:0] op, input logic [127:0] a,
                           input logic [127:0] b, input logic [31:0] csr,
                           input logic [2:0] post);
        @(negedge clk);
        in_op = op; in_a = a; in_b = b; in_csr = csr; in_post = post;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R2", "out_valid after reset", {127'd0, out_valid}, 128'd0);
        chk("R2", "in_ready after reset",  {127'd0, in_ready},  128'd1);
    endtask

    task automatic t_normal_add;
        run_txn(2'd0, {ONE, TWO, M3, ONE}, {TWO, ONE, ONE, M3}, MSK_ALL, 3'b000);
        chk_all("R11", 1'b0, 4'b0000, 4'b1111, '0, MSK_ALL);
    endtask

    task automatic t_snan;
        run_txn(2'd0, {ONE, 32'h7FC0_0010, ONE, 32'h7F80_0001},
                      {ONE, 32'h7F80_0002, 32'hFF80_0005, ONE}, MSK_ALL, 3'b000);
        chk_all("R3", 1'b0, 4'b0111, 4'b1000,
                {32'h0, 32'h7FC0_0010, 32'hFFC0_0005, 32'h7FC0_0001}, MSK_ALL | 32'h1);
    endtask

    task automatic t_qnan;
        run_txn(2'd2, {ONE, TWO, 32'h7FC0_0001, ONE},
                      {TWO, ONE, 32'h7FC0_0002, 32'hFFC1_2345}, MSK_ALL, 3'b000);
        chk_all("R4", 1'b0, 4'b0011, 4'b1100,
                {32'h0, 32'h0, 32'h7FC0_0001, 32'hFFC1_2345}, MSK_ALL);
    endtask

    task automatic t_inf_add_sub;
        run_txn(2'd0, {ONE, ONE, PINF, PINF}, {TWO, NINF, PINF, NINF}, MSK_ALL, 3'b000);
        chk_all("R5 add", 1'b0, 4'b0001, 4'b1110, {96'h0, 32'hFFC0_0000}, MSK_ALL | 32'h1);
        run_txn(2'd1, {ONE, NINF, NINF, PINF}, {TWO, NINF, PINF, PINF}, MSK_ALL, 3'b000);
        chk_all("R5 sub", 1'b0, 4'b0101, 4'b1010,
                {32'h0, 32'hFFC0_0000, 32'h0, 32'hFFC0_0000}, MSK_ALL | 32'h1);
    endtask

    task automatic t_div;
        run_txn(2'd2, {TWO, M3, PINF, 32'h0}, {32'h0, 32'h0, NINF, 32'h8000_0000},
                MSK_ALL, 3'b000);
        chk_all("R5 R7 div", 1'b0, 4'b1111, 4'b0000,
                {PINF, NINF, 32'hFFC0_0000, 32'hFFC0_0000}, MSK_ALL | 32'h5);
    endtask

    task automatic t_cvt;
        run_txn(2'd3, {32'hCF00_0000, 32'h4F00_0000, PINF, 32'h7FC0_0000},
                      {32'h0000_0001, 32'h7F80_0001, 32'h7F80_0001, 32'h7F80_0001},
                      MSK_ALL, 3'b000);
        chk_all("R6", 1'b0, 4'b0111, 4'b1000,
                {32'h0, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000}, MSK_ALL | 32'h1);
    endtask

    task automatic t_denormal;
        run_txn(2'd0, {ONE, ONE, ONE, 32'h0000_0001}, {TWO, TWO, TWO, ONE}, MSK_ALL, 3'b000);
        chk_all("R8 masked", 1'b0, 4'b0000, 4'b1111, '0, MSK_ALL | 32'h2);
        // denormal unmasked, but its lane is invalid: no denormal, no fault
        run_txn(2'd0, {ONE, ONE, ONE, 32'h7F80_0001}, {TWO, TWO, TWO, 32'h0040_0000},
                32'h0000_1E80, 3'b000);
        chk_all("R8 suppressed", 1'b0, 4'b0001, 4'b1110, {96'h0, 32'h7FC0_0001},
                32'h0000_1E81);
    endtask

    task automatic t_fault;
        run_txn(2'd0, {ONE, PINF, ONE, 32'h7FC0_0001}, {TWO, NINF, ONE, ONE},
                32'h0000_1F00, 3'b000);
        chk_all("R9 invalid", 1'b1, 4'b0000, 4'b0000, '0, 32'h0000_1F01);
        run_txn(2'd2, {ONE, ONE, ONE, ONE}, {32'h0, TWO, TWO, TWO},
                32'h0000_1D80, 3'b000);
        chk_all("R9 R10 divzero", 1'b1, 4'b0000, 4'b0000, '0, 32'h0000_1D84);
    endtask

    task automatic t_sticky;
        run_txn(2'd0, {ONE, ONE, ONE, ONE}, {ONE, ONE, ONE, ONE}, 32'h0000_3FC2, 3'b101);
        chk_all("R10", 1'b0, 4'b0000, 4'b1111, '0, 32'h0000_3FEA);
    endtask

    task automatic t_stall;
        @(negedge clk);
        out_ready = 1'b0;
        in_op = 2'd0; in_a = {4{ONE}}; in_b = {4{TWO}}; in_csr = MSK_ALL; in_post = 3'b000;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // second transaction waits while the first is held
        in_a = {ONE, ONE, ONE, 32'h7FC0_0003};
        chk("R1", "in_ready while stalled", {127'd0, in_ready}, 128'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R1 held", 1'b0, 4'b0000, 4'b1111, '0, MSK_ALL);
        chk("R1", "in_ready still low", {127'd0, in_ready}, 128'd0);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk_all("R1 next", 1'b0, 4'b0001, 4'b1110, {96'h0, 32'h7FC0_0003}, MSK_ALL);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "drained", {127'd0, out_valid}, 128'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_normal_add();
        t_snan();
        t_qnan();
        t_inf_add_sub();
        t_div();
        t_cvt();
        t_denormal();
        t_fault();
        t_sticky();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule